// File: doc/BRIEF.md
# Floating-Point Conditional Select Unit

This unit takes one 32-bit floating-point conditional-select instruction word and decodes it. It evaluates one of four fixed conditions against the N, Z, C and V flags. It then returns either the first or the second source operand as the result. The operand values come from an external register file, one 32-bit word per half. A single register stage holds the decoded register indices, the chosen value, a valid strobe and an undefined-instruction flag. All of these appear one clock after the word is offered.

The condition is a 2-bit field, not a general 4-bit condition code. Each of its four values maps to one fixed test on the flags. One instruction bit selects the precision:
- **Single precision** moves one 32-bit word.
- **Double precision** moves both halves of the chosen operand together.

The select copies operand bits exactly as they arrive. NaN payloads, signed zeros and infinities therefore come out unchanged, and the unit raises no arithmetic exception flags.

Top module: `fp_csel_unit`

## Requirements
- R1: A word with `in_valid` high is accepted only if all of these hold: bits 31:24 are 0xFE, bit 23 is 0, bits 11:9 are 0b101, bit 6 is 0 and bit 4 is 0. An accepted word gives `out_valid`=1 and `out_undef`=0 on the next cycle. Any other word gives `out_undef`=1 and `out_valid`=0 on the next cycle.
- R2: Bits 21:20 of the word select the condition. Code 0 holds when Z=1. Code 1 holds when V=1. Code 2 holds when N equals V. Code 3 holds when Z=0 and N equals V. The flags input is ordered {N,Z,C,V}, with N in bit 3.
- R3: When the condition holds, the result is the first source operand. When it does not hold, the result is the second source operand.
- R4: Bit 8 of the word selects precision, 1 for double, and this bit is shown on `out_dbl`. In double precision, `res_hi`/`res_lo` both come from the same chosen operand. In single precision, `res_lo` carries the chosen word and `res_hi` is 0.
- R5: In single precision, each 6-bit index is {0, field, extra}:
  - the destination uses field 15:12 with extra bit 22;
  - the first source uses field 19:16 with extra bit 7;
  - the second source uses field 3:0 with extra bit 5.
- R6: In double precision, each 6-bit index is {extra, field, 0}, using the same fields and extra bits as R5.
- R7: The C flag has no effect on the result of any condition.
- R8: Result bits equal the chosen operand bits exactly, including NaN payloads, negative zero and infinities.
- R9: When `in_valid` is low, or the word is undefined, the result and index outputs keep their previous values. When `in_valid` is low, neither `out_valid` nor `out_undef` is raised on the next cycle.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| insn | input | 32 | Instruction word |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| opn_lo | input | 32 | First source operand, low word |
| opn_hi | input | 32 | First source operand, high word (double only) |
| opm_lo | input | 32 | Second source operand, low word |
| opm_hi | input | 32 | Second source operand, high word (double only) |
| out_valid | output | 1 | Accepted select completed |
| out_undef | output | 1 | Offered word was undefined |
| out_dbl | output | 1 | Precision of the last accepted word |
| rd_idx | output | 6 | Destination register index |
| rn_idx | output | 6 | First source register index |
| rm_idx | output | 6 | Second source register index |
| res_lo | output | 32 | Selected value, low word |
| res_hi | output | 32 | Selected value, high word |

## Verification
Every result of this unit is due exactly one rising edge after the word is offered. This covers the valid and undefined strobes, the three indices, the precision bit and both result words. The bench drives a word on a falling edge and lets one rising edge pass. It then samples all outputs on the next falling edge, before anything else changes. To check that held values stay held, the bench offers an idle or undefined cycle and samples one edge later. It compares the outputs with the values left by the previous accepted word.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned IDX_W   = FIELD_W + 2;
  localparam int unsigned LANES   = 2;

  // flag vector layout {N,Z,C,V}
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  // 2-bit condition field codes
  typedef enum logic [1:0] {
    SEL_EQ = 2'd0,
    SEL_VS = 2'd1,
    SEL_GE = 2'd2,
    SEL_GT = 2'd3
  } sel_cond_e;

  typedef struct packed {
    logic             hit;
    logic             dbl;
    sel_cond_e        cond;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } dec_t;

  // Index formation: single = {0, field, extra}; double = {extra, field, 0}
  function automatic logic [IDX_W-1:0] make_idx(input logic [FIELD_W-1:0] fld,
                                                input logic ext,
                                                input logic dbl);
    logic [IDX_W-1:0] r;
    if (dbl) r = {ext, fld, 1'b0};
    else     r = {1'b0, fld, ext};
    return r;
  endfunction

endpackage

// File: rtl/fpcs_decode.sv
module fpcs_decode
  import fpcs_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output dec_t              dec
);
  localparam logic [7:0] TOP_TAG  = 8'hFE;
  localparam logic [2:0] MID_TAG  = 3'b101;

  logic top_ok;
  logic mid_ok;
  logic zero_ok;

  always_comb begin
    top_ok  = (insn[31:24] == TOP_TAG);
    mid_ok  = (insn[11:9] == MID_TAG);
    zero_ok = ~insn[23] & ~insn[6] & ~insn[4];
  end

  always_comb begin
    dec.hit  = top_ok & mid_ok & zero_ok;
    dec.dbl  = insn[8];
    dec.cond = sel_cond_e'(insn[21:20]);
    dec.rd   = make_idx(insn[15:12], insn[22], insn[8]);
    dec.rn   = make_idx(insn[19:16], insn[7],  insn[8]);
    dec.rm   = make_idx(insn[3:0],   insn[5],  insn[8]);
  end

endmodule

// File: rtl/fpcs_cond_eval.sv
module fpcs_cond_eval
  import fpcs_pkg::*;
(
  input  sel_cond_e  cond,
  input  logic [3:0] flags,
  output logic       take_n
);
  logic n_f, z_f, v_f;
  logic unused_carry;

  always_comb begin
    n_f = flags[FLAG_N];
    z_f = flags[FLAG_Z];
    v_f = flags[FLAG_V];
    unused_carry = flags[FLAG_C];
  end

  always_comb begin
    unique case (cond)
      SEL_EQ:  take_n = z_f;
      SEL_VS:  take_n = v_f;
      SEL_GE:  take_n = (n_f == v_f);
      SEL_GT:  take_n = ~z_f & (n_f == v_f);
      default: take_n = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpcs_lane_mux.sv
module fpcs_lane_mux #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NLANE  = 2
) (
  input  logic                    take_n,
  input  logic [NLANE-1:0]        lane_en,
  input  logic [NLANE*LANE_W-1:0] src_n,
  input  logic [NLANE*LANE_W-1:0] src_m,
  output logic [NLANE*LANE_W-1:0] dst
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] pick;
    always_comb begin
      pick = take_n ? src_n[g*LANE_W +: LANE_W] : src_m[g*LANE_W +: LANE_W];
      dst[g*LANE_W +: LANE_W] = lane_en[g] ? pick : '0;
    end
  end
endmodule

// File: rtl/fp_csel_unit.sv
module fp_csel_unit
  import fpcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] insn,
  input  logic [3:0]        flags,
  input  logic [WORD_W-1:0] opn_lo,
  input  logic [WORD_W-1:0] opn_hi,
  input  logic [WORD_W-1:0] opm_lo,
  input  logic [WORD_W-1:0] opm_hi,
  output logic              out_valid,
  output logic              out_undef,
  output logic              out_dbl,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rn_idx,
  output logic [IDX_W-1:0]  rm_idx,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);
  localparam int unsigned DATA_W = LANES * WORD_W;

  dec_t              dec;
  logic              take_n;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] sel_data;

  fpcs_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  fpcs_cond_eval u_cond (
    .cond   (dec.cond),
    .flags  (flags),
    .take_n (take_n)
  );

  always_comb begin
    lane_en    = '0;
    lane_en[0] = 1'b1;
    for (int i = 1; i < LANES; i++) lane_en[i] = dec.dbl;
  end

  fpcs_lane_mux #(.LANE_W(WORD_W), .NLANE(LANES)) u_mux (
    .take_n  (take_n),
    .lane_en (lane_en),
    .src_n   ({opn_hi, opn_lo}),
    .src_m   ({opm_hi, opm_lo}),
    .dst     (sel_data)
  );

  // next state
  logic              accept;
  logic              nxt_valid, nxt_undef;
  logic              nxt_dbl;
  logic [IDX_W-1:0]  nxt_rd, nxt_rn, nxt_rm;
  logic [DATA_W-1:0] nxt_res;
  logic [DATA_W-1:0] res_q;

  always_comb begin
    accept    = in_valid & dec.hit;
    nxt_valid = accept;
    nxt_undef = in_valid & ~dec.hit;
    nxt_dbl   = dec.dbl;
    nxt_rd    = dec.rd;
    nxt_rn    = dec.rn;
    nxt_rm    = dec.rm;
    nxt_res   = sel_data;
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
      out_undef <= nxt_undef;
    end
  end

  // payload, enabled only by an accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dbl <= 1'b0;
      rd_idx  <= '0;
      rn_idx  <= '0;
      rm_idx  <= '0;
      res_q   <= '0;
    end else if (accept) begin
      out_dbl <= nxt_dbl;
      rd_idx  <= nxt_rd;
      rn_idx  <= nxt_rn;
      rm_idx  <= nxt_rm;
      res_q   <= nxt_res;
    end
  end

  always_comb begin
    res_lo = res_q[0 +: WORD_W];
    res_hi = res_q[WORD_W +: WORD_W];
  end

endmodule

// File: rtl/fpcs_checker.sv
module fpcs_checker
  import fpcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] insn,
  input logic [3:0]        flags,
  input logic [WORD_W-1:0] opn_lo,
  input logic [WORD_W-1:0] opn_hi,
  input logic [WORD_W-1:0] opm_lo,
  input logic [WORD_W-1:0] opm_hi,
  input logic              out_valid,
  input logic              out_undef,
  input logic              out_dbl,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [IDX_W-1:0]  rn_idx,
  input logic [IDX_W-1:0]  rm_idx,
  input logic [WORD_W-1:0] res_lo,
  input logic [WORD_W-1:0] res_hi
);
  // R1: strobes are exclusive
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_undef));

  // R9: no strobe after an idle cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_undef));

  // R9: result held when nothing is accepted
  p_hold_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(res_lo) && $stable(res_hi) && $stable(rd_idx)));

  // R4: single precision clears the upper word
  p_single_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dbl) |-> (res_hi == '0));

  // R3: result always one of the offered operands
  p_from_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_lo == $past(opn_lo) || res_lo == $past(opm_lo)));

  // R2: equal condition with Z set picks the first source
  p_eq_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[21:20] == 2'd0 && flags[FLAG_Z]) |=>
      (!out_valid || res_lo == $past(opn_lo)));

  // R6: double precision indices are even
  p_dbl_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dbl) |-> (!rd_idx[0] && !rn_idx[0] && !rm_idx[0]));

  // R5: single precision indices stay below 32
  p_sgl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dbl) |-> (!rd_idx[IDX_W-1] && !rn_idx[IDX_W-1] && !rm_idx[IDX_W-1]));

  logic unused_chk;
  assign unused_chk = ^{opn_hi, opm_hi};
endmodule

bind fp_csel_unit fpcs_checker u_chk (.*);

// File: tb/tb_fp_csel_unit.sv
module tb_fp_csel_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [3:0]  flags;
  logic [31:0] opn_lo, opn_hi, opm_lo, opm_hi;
  logic        out_valid, out_undef, out_dbl;
  logic [5:0]  rd_idx, rn_idx, rm_idx;
  logic [31:0] res_lo, res_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fp_csel_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .flags(flags),
    .opn_lo(opn_lo), .opn_hi(opn_hi), .opm_lo(opm_lo), .opm_hi(opm_hi),
    .out_valid(out_valid), .out_undef(out_undef), .out_dbl(out_dbl),
    .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx),
    .res_lo(res_lo), .res_hi(res_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] c, input logic dbl,
                                     input logic [3:0] df, input logic de,
                                     input logic [3:0] nf, input logic ne,
                                     input logic [3:0] mf, input logic me);
    logic [31:0] w;
    w = 32'hFE000A00;
    w[21:20] = c;  w[8] = dbl;
    w[15:12] = df; w[22] = de;
    w[19:16] = nf; w[7]  = ne;
    w[3:0]   = mf; w[5]  = me;
    return w;
  endfunction

  function automatic logic holds(input logic [1:0] c, input logic [3:0] f);
    logic n, z, v;
    n = f[3]; z = f[2]; v = f[0];
    case (c)
      2'd0: return z;
      2'd1: return v;
      2'd2: return n == v;
      default: return !z && (n == v);
    endcase
  endfunction

  function automatic logic [5:0] xidx(input logic [3:0] f, input logic e, input logic dbl);
    return dbl ? {e, f, 1'b0} : {1'b0, f, e};
  endfunction

  // drive on falling edge, sample one rising edge later on the next falling edge
  task automatic issue(input logic v, input logic [31:0] w, input logic [3:0] f,
                       input logic [31:0] nl, input logic [31:0] nh,
                       input logic [31:0] ml, input logic [31:0] mh);
    @(negedge clk);
    in_valid = v; insn = w; flags = f;
    opn_lo = nl; opn_hi = nh; opm_lo = ml; opm_hi = mh;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 valid", {63'd0, out_valid}, 64'd0);
    chk("R10 undef", {63'd0, out_undef}, 64'd0);
    chk("R10 res",   {res_hi, res_lo}, 64'd0);
    chk("R10 idx",   {46'd0, rd_idx, rn_idx, rm_idx}, 64'd0);
  endtask

  task automatic t_cond_table;
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] a, b;
        a = 32'h3F800000 + f;
        b = 32'hC0000000 + (c << 8) + f;
        issue(1'b1, mk(2'(c), 1'b0, 4'h1, 1'b0, 4'h2, 1'b0, 4'h3, 1'b0), 4'(f), a, 32'h0, b, 32'h0);
        chk("R1 valid", {63'd0, out_valid}, 64'd1);
        chk("R2 R3 select", {32'd0, res_lo}, {32'd0, holds(2'(c), 4'(f)) ? a : b});
      end
    end
  endtask

  task automatic t_carry;
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] r0;
        issue(1'b1, mk(2'(c), 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'(f) & 4'b1101,
              32'h11111111, 32'h0, 32'h22222222, 32'h0);
        r0 = res_lo;
        issue(1'b1, mk(2'(c), 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'(f) | 4'b0010,
              32'h11111111, 32'h0, 32'h22222222, 32'h0);
        chk("R7 carry ignored", {32'd0, res_lo}, {32'd0, r0});
      end
    end
  endtask

  task automatic t_single_idx;
    issue(1'b1, mk(2'd0, 1'b0, 4'hA, 1'b1, 4'h5, 1'b0, 4'hF, 1'b1), 4'b0100,
          32'h01234567, 32'hDEADBEEF, 32'h89ABCDEF, 32'hCAFEF00D);
    chk("R5 rd", {58'd0, rd_idx}, {58'd0, xidx(4'hA, 1'b1, 1'b0)});
    chk("R5 rn", {58'd0, rn_idx}, {58'd0, xidx(4'h5, 1'b0, 1'b0)});
    chk("R5 rm", {58'd0, rm_idx}, {58'd0, xidx(4'hF, 1'b1, 1'b0)});
    chk("R4 single dbl flag", {63'd0, out_dbl}, 64'd0);
    chk("R4 single hi zero", {res_hi, res_lo}, {32'd0, 32'h01234567});
  endtask

  task automatic t_double;
    issue(1'b1, mk(2'd3, 1'b1, 4'h7, 1'b1, 4'h3, 1'b0, 4'hC, 1'b1), 4'b0000,
          32'h0000AAAA, 32'h4000BBBB, 32'h0000CCCC, 32'hC000DDDD);
    chk("R4 double flag", {63'd0, out_dbl}, 64'd1);
    chk("R4 double taken", {res_hi, res_lo}, {32'h4000BBBB, 32'h0000AAAA});
    chk("R6 rd", {58'd0, rd_idx}, {58'd0, xidx(4'h7, 1'b1, 1'b1)});
    chk("R6 rn", {58'd0, rn_idx}, {58'd0, xidx(4'h3, 1'b0, 1'b1)});
    chk("R6 rm", {58'd0, rm_idx}, {58'd0, xidx(4'hC, 1'b1, 1'b1)});
    issue(1'b1, mk(2'd3, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'b0100,
          32'h0000AAAA, 32'h4000BBBB, 32'h0000CCCC, 32'hC000DDDD);
    chk("R4 double not taken", {res_hi, res_lo}, {32'hC000DDDD, 32'h0000CCCC});
  endtask

  task automatic t_special;
    issue(1'b1, mk(2'd1, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'b0001,
          32'h7FC12345, 32'h0, 32'h80000000, 32'h0);
    chk("R8 nan payload", {32'd0, res_lo}, {32'd0, 32'h7FC12345});
    issue(1'b1, mk(2'd1, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'b0000,
          32'h7FC12345, 32'h0, 32'h80000000, 32'h0);
    chk("R8 neg zero", {32'd0, res_lo}, {32'd0, 32'h80000000});
    issue(1'b1, mk(2'd2, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'b1001,
          32'h00000000, 32'hFFF00000, 32'h1, 32'h2);
    chk("R8 neg inf double", {res_hi, res_lo}, {32'hFFF00000, 32'h00000000});
  endtask

  task automatic t_undef;
    logic [31:0] good;
    logic [31:0] bads [5];
    good = mk(2'd0, 1'b0, 4'h4, 1'b0, 4'h4, 1'b0, 4'h4, 1'b0);
    bads[0] = good ^ 32'h00800000;
    bads[1] = good ^ 32'h00000040;
    bads[2] = good ^ 32'h00000010;
    bads[3] = good ^ 32'h00000200;
    bads[4] = good ^ 32'h01000000;
    issue(1'b1, good, 4'b0100, 32'h5555AAAA, 32'h0, 32'h0, 32'h0);
    for (int i = 0; i < 5; i++) begin
      issue(1'b1, bads[i], 4'b0000, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F, 32'hF0F0F0F0);
      chk("R1 undef flag", {63'd0, out_undef}, 64'd1);
      chk("R1 undef no valid", {63'd0, out_valid}, 64'd0);
      chk("R9 undef holds res", {res_hi, res_lo}, {32'd0, 32'h5555AAAA});
      chk("R9 undef holds idx", {58'd0, rd_idx}, {58'd0, xidx(4'h4, 1'b0, 1'b0)});
    end
  endtask

  task automatic t_idle;
    issue(1'b1, mk(2'd0, 1'b0, 4'h9, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0), 4'b0100,
          32'h600DF00D, 32'h0, 32'h0, 32'h0);
    issue(1'b0, mk(2'd0, 1'b0, 4'h2, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0), 4'b0000,
          32'h11111111, 32'h0, 32'h22222222, 32'h0);
    chk("R9 idle no valid", {63'd0, out_valid}, 64'd0);
    chk("R9 idle no undef", {63'd0, out_undef}, 64'd0);
    chk("R9 idle holds res", {32'd0, res_lo}, {32'd0, 32'h600DF00D});
    chk("R9 idle holds idx", {58'd0, rd_idx}, {58'd0, xidx(4'h9, 1'b0, 1'b0)});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; flags = '0;
    opn_lo = '0; opn_hi = '0; opm_lo = '0; opm_hi = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_cond_table;
    t_carry;
    t_single_idx;
    t_double;
    t_special;
    t_undef;
    t_idle;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule